// File: doc/BRIEF.md
# Swizzled Tile Address Generator

This block converts a logical element coordinate (row m, column k) of a 64-row by 32-column tile of 16-bit values into a physical element offset inside a banked scratch memory. In its default mode the tile is split into 8-element packs along k. Pack positions are then permuted with an XOR key taken from the row group. This spreads both row-wise pack writes and pack reads that run down a column across all banks. The 8 elements of a pack always stay contiguous and in order. A parameter selects a second layout that uses a plain padded row pitch of 34 elements and no permutation. A bank-count parameter of 64 widens the layer factor, and it doubles the row range over which the XOR key is drawn.

Two paths share the mapping. A combinational lookup port returns the offset for any coordinate in the same cycle. A streaming port accepts a start coordinate and a direction. It then produces eight consecutive addresses, one per clock, stepping along k or along m. It flags the eighth address. The swizzle is computed separately for every streamed element. No step is ever added to an already swizzled base.

Top module: `swz_tile_addr`

## Requirements
- R1: In the default layout (32 banks), with b = m/2, l = m mod 2, k0 = k/8, p = k mod 8 and a = 4·l + k0, the lookup offset equals 8·(a XOR (b mod 8)) + 64·b + p, in the same cycle as the coordinate.
- R2: In the default layout the low three bits of every offset equal k mod 8, so the pack index is never permuted.
- R3: In the default layout the 2048 coordinates map to 2048 distinct offsets, all below 2048.
- R4: In the default layout, for any k0 and any aligned group of 8 consecutive rows (8j to 8j+7), the eight pack start offsets at column 8·k0 fall into eight distinct 4-bank groups, where the group index is (offset/8) mod 8.
- R5: With the padded layout selected the offset is 34·m + k.
- R6: A start pulse on an idle streamer produces valid addresses on the eight clocks that follow the accepting edge. With direction 0 (along k) beat i carries the offset of (m, k+i). The last flag is high only on beat 8.
- R7: With direction 1 (along m), beat i carries the offset of (m+i, k).
- R8: A start pulse while a burst is in progress, including its last beat, is ignored. Valid is low in the cycle after the last beat.
- R9: During and right after reset, valid and last are low.
- R10: A streamed coordinate wraps modulo the tile size: k modulo 32 and m modulo 64.
- R11: With 64 banks the layer factor is 4 and the key range is doubled: a = 4·(m mod 4) + k0, key = (m/2) mod 16, and offset = 8·(a XOR key) + 128·(m/4) + p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_m | input | 6 | Lookup row coordinate |
| lk_k | input | 5 | Lookup column coordinate |
| lk_ofs | output | 12 | Lookup physical element offset |
| st_start | input | 1 | Start a streaming burst (accepted when idle) |
| st_m | input | 6 | Burst start row |
| st_k | input | 5 | Burst start column |
| st_dir | input | 1 | Burst direction: 0 steps k, 1 steps m |
| st_valid | output | 1 | Streamed address valid |
| st_last | output | 1 | Eighth address of the burst |
| st_ofs | output | 12 | Streamed physical element offset |

## Verification
A lookup result is due in the same cycle as its coordinate, so the bench applies a coordinate and compares one time step later, with no clock edge involved. A streaming burst shows its first address in the cycle after the rising edge that samples the start pulse, and its eighth address seven cycles later. The bench model pops and loads its queue of expected beats at each rising edge and compares the queue head with the outputs at every falling edge. Ignored start pulses are placed both mid-burst and in the last-beat cycle, and the cycle after that beat is checked for an idle output.

// File: rtl/swz_pkg.sv
package swz_pkg;
   typedef enum logic {
      DIR_K = 1'b0,
      DIR_M = 1'b1
   } swz_dir_e;

   function automatic bit is_pow2(int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/swz_map.sv
module swz_map #(
   parameter int ROWS       = 64,
   parameter int COLS       = 32,
   parameter int PACK       = 8,
   parameter int ELEM_BYTES = 2,
   parameter int NBANKS     = 32,
   parameter int PAD_MODE   = 0,
   parameter int PAD_ELEMS  = 2,
   parameter int MW         = $clog2(ROWS),
   parameter int KW         = $clog2(COLS),
   parameter int OFS_W      = $clog2(ROWS * (COLS + PAD_ELEMS))
) (
   input  logic [MW-1:0]    m,
   input  logic [KW-1:0]    k,
   output logic [OFS_W-1:0] ofs
);
   localparam int LAYER     = NBANKS * 4 / (COLS * ELEM_BYTES);
   localparam int ROWMUL    = (NBANKS == 64) ? 2 : 1;
   localparam int K0N       = COLS / PACK;
   localparam int A_N       = K0N * LAYER;
   localparam int KEY_DIV   = LAYER / ROWMUL;
   localparam int PHYS_ROW  = A_N * PACK;
   localparam int ROW_PITCH = COLS + PAD_ELEMS;

   if (OFS_W < $clog2(ROWS * ROW_PITCH)) begin : g_bad_w
      $error("swz_map: offset width too small");
   end
   if (LAYER < ROWMUL || (ROWS % LAYER) != 0) begin : g_bad_layer
      $error("swz_map: layer factor does not fit the tile");
   end

   logic [31:0] mi, ki;
   assign mi = 32'(m);
   assign ki = 32'(k);

   if (PAD_MODE != 0) begin : g_pad
      always_comb ofs = OFS_W'(mi * ROW_PITCH + ki);
   end else begin : g_xor
      logic [31:0] b, l, k0, p, a, key;
      always_comb begin
         b   = mi / LAYER;
         l   = mi % LAYER;
         k0  = ki / PACK;
         p   = ki % PACK;
         a   = l * K0N + k0;
         key = (mi / KEY_DIV) % A_N;
         ofs = OFS_W'(((a ^ key) * PACK) + b * PHYS_ROW + p);
      end
   end
endmodule

// File: rtl/swz_stream.sv
module swz_stream
   import swz_pkg::*;
#(
   parameter int ROWS = 64,
   parameter int COLS = 32,
   parameter int PACK = 8,
   parameter int MW   = $clog2(ROWS),
   parameter int KW   = $clog2(COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [MW-1:0] start_m,
   input  logic [KW-1:0] start_k,
   input  swz_dir_e      dir,
   output logic          valid,
   output logic          last,
   output logic [MW-1:0] cur_m,
   output logic [KW-1:0] cur_k
);
   localparam int CW = $clog2(PACK);

   logic          active;
   logic [CW-1:0] cnt;
   swz_dir_e      dir_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         dir_q  <= DIR_K;
         cur_m  <= '0;
         cur_k  <= '0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            dir_q  <= dir;
            cur_m  <= start_m;
            cur_k  <= start_k;
         end
      end else begin
         if (cnt == CW'(PACK - 1)) active <= 1'b0;
         cnt <= cnt + 1'b1;
         if (dir_q == DIR_K) cur_k <= cur_k + 1'b1;
         else                cur_m <= cur_m + 1'b1;
      end
   end

   assign valid = active;
   assign last  = active && (cnt == CW'(PACK - 1));
endmodule

// File: rtl/swz_tile_addr.sv
module swz_tile_addr
   import swz_pkg::*;
#(
   parameter int ROWS       = 64,
   parameter int COLS       = 32,
   parameter int PACK       = 8,
   parameter int ELEM_BYTES = 2,
   parameter int NBANKS     = 32,
   parameter int PAD_MODE   = 0,
   parameter int PAD_ELEMS  = 2,
   parameter int MW         = $clog2(ROWS),
   parameter int KW         = $clog2(COLS),
   parameter int OFS_W      = $clog2(ROWS * (COLS + PAD_ELEMS))
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MW-1:0]    lk_m,
   input  logic [KW-1:0]    lk_k,
   output logic [OFS_W-1:0] lk_ofs,
   input  logic             st_start,
   input  logic [MW-1:0]    st_m,
   input  logic [KW-1:0]    st_k,
   input  logic             st_dir,
   output logic             st_valid,
   output logic             st_last,
   output logic [OFS_W-1:0] st_ofs
);
   if (!is_pow2(ROWS) || !is_pow2(COLS) || !is_pow2(PACK) || PACK < 2) begin : g_bad_dim
      $error("swz_tile_addr: dimensions must be powers of two");
   end
   if (NBANKS != 32 && NBANKS != 64) begin : g_bad_banks
      $error("swz_tile_addr: bank count must be 32 or 64");
   end
   if ((COLS % PACK) != 0) begin : g_bad_pack
      $error("swz_tile_addr: pack must divide the column count");
   end

   logic [MW-1:0] cur_m;
   logic [KW-1:0] cur_k;
   swz_dir_e      dir_e;

   assign dir_e = swz_dir_e'(st_dir);

   swz_stream #(.ROWS(ROWS), .COLS(COLS), .PACK(PACK), .MW(MW), .KW(KW)) u_stream (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (st_start),
      .start_m (st_m),
      .start_k (st_k),
      .dir     (dir_e),
      .valid   (st_valid),
      .last    (st_last),
      .cur_m   (cur_m),
      .cur_k   (cur_k)
   );

   swz_map #(
      .ROWS(ROWS), .COLS(COLS), .PACK(PACK), .ELEM_BYTES(ELEM_BYTES),
      .NBANKS(NBANKS), .PAD_MODE(PAD_MODE), .PAD_ELEMS(PAD_ELEMS),
      .MW(MW), .KW(KW), .OFS_W(OFS_W)
   ) u_map_lk (
      .m   (lk_m),
      .k   (lk_k),
      .ofs (lk_ofs)
   );

   swz_map #(
      .ROWS(ROWS), .COLS(COLS), .PACK(PACK), .ELEM_BYTES(ELEM_BYTES),
      .NBANKS(NBANKS), .PAD_MODE(PAD_MODE), .PAD_ELEMS(PAD_ELEMS),
      .MW(MW), .KW(KW), .OFS_W(OFS_W)
   ) u_map_st (
      .m   (cur_m),
      .k   (cur_k),
      .ofs (st_ofs)
   );
endmodule

// File: rtl/swz_tile_addr_chk.sv
module swz_tile_addr_chk #(
   parameter int ROWS      = 64,
   parameter int COLS      = 32,
   parameter int PACK      = 8,
   parameter int PAD_MODE  = 0,
   parameter int PAD_ELEMS = 2,
   parameter int KW        = 5,
   parameter int OFS_W     = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [KW-1:0]    lk_k,
   input logic [OFS_W-1:0] lk_ofs,
   input logic             st_valid,
   input logic             st_last
);
   localparam int LIMIT = ROWS * (COLS + ((PAD_MODE != 0) ? PAD_ELEMS : 0));
   localparam int VW    = $clog2(PACK) + 1;

   logic [VW-1:0] beat;

   always_ff @(posedge clk) begin
      if (!rst_n)                    beat <= '0;
      else if (st_valid && !st_last) beat <= beat + 1'b1;
      else                           beat <= '0;
   end

   AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      st_last |-> (st_valid && beat == VW'(PACK - 1))); // R6
   AST_BURST_CONT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_last) |=> st_valid); // R6
   AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      st_last |=> !st_valid); // R8
   AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(lk_ofs) < LIMIT); // R3

   if (PAD_MODE == 0) begin : g_pack
      AST_PACK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         32'(lk_ofs) % PACK == 32'(lk_k) % PACK); // R2
   end
endmodule

bind swz_tile_addr swz_tile_addr_chk #(
   .ROWS(ROWS), .COLS(COLS), .PACK(PACK), .PAD_MODE(PAD_MODE),
   .PAD_ELEMS(PAD_ELEMS), .KW(KW), .OFS_W(OFS_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_k     (lk_k),
   .lk_ofs   (lk_ofs),
   .st_valid (st_valid),
   .st_last  (st_last)
);

// File: tb/sim_swz_tile_addr.sv
`timescale 1ns/1ps
module sim_swz_tile_addr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  lk_m = '0;
   logic [4:0]  lk_k = '0;
   logic        st_start = 1'b0;
   logic [5:0]  st_m = '0;
   logic [4:0]  st_k = '0;
   logic        st_dir = 1'b0;
   logic [11:0] ofs0, ofs1, ofs2, sofs0, sofs1, sofs2;
   logic        sv0, sl0, sv1, sl1, sv2, sl2;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string tag = "R9";

   typedef struct { int ofs; bit last; } beat_t;
   beat_t q[$];

   always #10 clk = ~clk;

   swz_tile_addr u0 (
      .clk(clk), .rst_n(rst_n), .lk_m(lk_m), .lk_k(lk_k), .lk_ofs(ofs0),
      .st_start(st_start), .st_m(st_m), .st_k(st_k), .st_dir(st_dir),
      .st_valid(sv0), .st_last(sl0), .st_ofs(sofs0));
   swz_tile_addr #(.PAD_MODE(1)) u1 (
      .clk(clk), .rst_n(rst_n), .lk_m(lk_m), .lk_k(lk_k), .lk_ofs(ofs1),
      .st_start(1'b0), .st_m(st_m), .st_k(st_k), .st_dir(st_dir),
      .st_valid(sv1), .st_last(sl1), .st_ofs(sofs1));
   swz_tile_addr #(.NBANKS(64)) u2 (
      .clk(clk), .rst_n(rst_n), .lk_m(lk_m), .lk_k(lk_k), .lk_ofs(ofs2),
      .st_start(1'b0), .st_m(st_m), .st_k(st_k), .st_dir(st_dir),
      .st_valid(sv2), .st_last(sl2), .st_ofs(sofs2));

   function automatic int ref_ofs(int m, int k, int nbanks, bit pad);
      int layer, rowmul, a_n, a, key;
      if (pad) return m * 34 + k;
      layer  = nbanks * 4 / 64;
      rowmul = (nbanks == 64) ? 2 : 1;
      a_n    = 4 * layer;
      a      = (m % layer) * 4 + k / 8;
      key    = (m / (layer / rowmul)) % a_n;
      return ((a ^ key) * 8) + (m / layer) * (a_n * 8) + (k % 8);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_sim();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // reference model of the streamer, advanced at every rising edge
   always @(posedge clk) begin
      if (!rst_n) q.delete();
      else if (q.size() > 0) void'(q.pop_front());
      else if (st_start) begin
         for (int i = 0; i < 8; i++) begin
            beat_t e;
            int mm, kk;
            mm = st_dir ? (st_m + i) % 64 : st_m;
            kk = st_dir ? st_k : (st_k + i) % 32;
            e.ofs = ref_ofs(mm, kk, 32, 0);
            e.last = (i == 7);
            q.push_back(e);
         end
      end
   end

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (!rst_n) begin
         check("R9 valid in reset", sv0, 0);
         check("R9 last in reset", sl0, 0);
      end else begin
         check({tag, " valid"}, sv0, q.size() > 0);
         if (q.size() > 0) begin
            check({tag, " ofs"}, sofs0, q[0].ofs);
            check({tag, " last"}, sl0, q[0].last);
         end else begin
            check({tag, " last idle"}, sl0, 0);
         end
      end
   end

   task automatic lookup(int m, int k);
      lk_m = 6'(m);
      lk_k = 5'(k);
      #1;
   endtask

   task automatic go(int m, int k, bit dir);
      @(negedge clk);
      st_m = 6'(m); st_k = 5'(k); st_dir = dir; st_start = 1'b1;
      @(negedge clk);
      st_start = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      bit seen[2048];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 valid after reset", sv0, 0);
      check("R9 last after reset", sl0, 0);

      // R1 R2 R3 R5 R11: full sweeps of the lookup port
      for (int m = 0; m < 64; m++) begin
         for (int k = 0; k < 32; k++) begin
            lookup(m, k);
            check("R1 xor offset", ofs0, ref_ofs(m, k, 32, 0));
            check("R2 pack bits", ofs0 % 8, k % 8);
            check("R5 padded offset", ofs1, m * 34 + k);
            check("R11 64-bank offset", ofs2, ref_ofs(m, k, 64, 0));
            if (ofs0 < 2048) begin
               check("R3 unique", seen[ofs0], 0);
               seen[ofs0] = 1;
            end else begin
               check("R3 range", ofs0, 0);
            end
         end
      end

      // R4: pack reads down 8 aligned rows hit 8 distinct bank groups
      for (int k0 = 0; k0 < 4; k0++) begin
         for (int j = 0; j < 8; j++) begin
            logic [7:0] mask = '0;
            for (int r = 0; r < 8; r++) begin
               lookup(8 * j + r, 8 * k0);
               mask[(ofs0 / 8) % 8] = 1'b1;
            end
            check("R4 bank groups", mask, 8'hFF);
         end
      end

      tag = "R6 along k";
      go(5, 8, 0);
      repeat (9) @(negedge clk);
      tag = "R7 along m";
      go(10, 3, 1);
      repeat (9) @(negedge clk);
      tag = "R10 k wrap";
      go(0, 28, 0);
      repeat (9) @(negedge clk);
      tag = "R10 m wrap";
      go(60, 17, 1);
      repeat (9) @(negedge clk);

      tag = "R8 busy start";
      go(1, 0, 0);
      repeat (2) @(negedge clk);
      st_m = 6'd40; st_k = 5'd9; st_dir = 1'b1; st_start = 1'b1;
      @(negedge clk);
      st_start = 1'b0;
      repeat (4) @(negedge clk);
      st_m = 6'd33; st_k = 5'd2; st_start = 1'b1;
      @(negedge clk);
      st_start = 1'b0;
      check("R8 idle after last", sv0, 0);
      repeat (3) @(negedge clk);
      check("R8 stays idle", sv0, 0);

      tag = "R7 after idle";
      go(63, 31, 1);
      repeat (10) @(negedge clk);
      finish_sim();
   end
endmodule